// File: doc/BRIEF.md
# BCD Real-Time Clock Core with Freezable Register Window

This block keeps calendar time: seconds, minutes, hours, day of week, date, month and a two-digit year, all as 24-hour BCD bytes. A prescaler divides a slow oscillator enable (`tick_en`) down to one-second steps. The running counters are never read directly by the host. A separate bank of visible time registers takes a copy of all counter fields at once, one cycle after each second step.

The host reaches the visible bank and a control byte through a single-cycle synchronous register port. The control byte holds two freeze bits. The hold bit (bit 6) stops the copy so that a multi-byte read sees one consistent instant. The set bit (bit 7) stops the copy and opens the time registers to host writes. When the set bit is cleared, the whole visible bank is moved into the counters in one cycle, and the prescaler restarts from zero. Timekeeping continues throughout every freeze.

Register offsets: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the visible bank reads seconds 00, minutes 00, hours 00, day 01, date 01, month 01, year 00, and the control byte reads 00.
- R2: The counters advance by one second on every TICK_DIV-th cycle with `tick_en` high, and on no other cycle.
- R3: With both freeze bits clear, every visible time field takes the counter value one clock after the counters step, all fields in the same cycle.
- R4: While control bit 6 (hold) is 1, the visible time registers keep their values, and the counters keep running underneath.
- R5: A control write that sets the hold bit in the same cycle as a pending copy does not cancel that copy. The registers show the newly stepped time.
- R6: Clearing a freeze bit does not itself refresh the registers. They take new values at the next second step.
- R7: Host writes to offsets 1 to 7 change the register only while control bit 7 (set) is 1. Otherwise they are ignored.
- R8: A control write that clears bit 7 while it is 1 copies all seven visible fields into the counters in that cycle and clears the prescaler, so that the next step comes after TICK_DIV further `tick_en` cycles.
- R9: Seconds and minutes wrap from 59 to 00, hours from 23 to 00, and day of week from 07 to 01, each carrying into the next field.
- R10: The date wraps to 01 after 31, 30 or 28/29 according to the month. February has 29 days when the BCD year is a multiple of four.
- R11: The month wraps from 12 to 01 and carries into the year, which wraps from 99 to 00.
- R12: A host value outside a field's BCD range is stored and read back as written, loaded as written, and replaced by the field's lowest value with a carry at the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Oscillator enable, one per prescaler count |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` (same cycle when RD_REG=0) |

## Verification
The rollover assertions assume that the counters hold valid BCD values when they wrap. That holds because the stimulus loads out-of-range bytes only in the dedicated R12 case, and it checks only the field that wraps. The refresh and hold properties assume that the host issues at most one register access per cycle and only drives `tick_en` as a single-cycle enable, and every bench task does this. The bench sweeps every month-end across four consecutive years against an arithmetic calendar model. It places freeze and load writes at chosen cycle offsets relative to a second step.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef struct packed {
      logic [7:0] year;
      logic [7:0] month;
      logic [7:0] date;
      logic [7:0] day;
      logic [7:0] hour;
      logic [7:0] minute;
      logic [7:0] second;
   } rtc_time_t;

   typedef enum logic [2:0] {
      OFS_CTRL  = 3'd0,
      OFS_SEC   = 3'd1,
      OFS_MIN   = 3'd2,
      OFS_HOUR  = 3'd3,
      OFS_DAY   = 3'd4,
      OFS_DATE  = 3'd5,
      OFS_MONTH = 3'd6,
      OFS_YEAR  = 3'd7
   } rtc_ofs_e;

   localparam rtc_time_t RTC_INIT = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                      day: 8'h01, hour: 8'h00, minute: 8'h00,
                                      second: 8'h00};

   // {wrap, next}: wraps to 'low' when v has reached or passed 'lim'
   function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                           input logic [7:0] lim,
                                           input logic [7:0] low);
      if (v >= lim)          return {1'b1, low};
      if (v[3:0] >= 4'd9)    return {1'b0, v[7:4] + 4'd1, 4'd0};
      return {1'b0, v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic [7:0] last_date(input logic [7:0] month,
                                            input logic [7:0] year);
      logic [5:0] m4;
      // tens*10 + ones is congruent to tens*2 + ones modulo 4
      m4 = {1'b0, year[7:4], 1'b0} + {2'b00, year[3:0]};
      case (month)
         8'h02:                      return (m4[1:0] == 2'b00) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int TICK_DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic clear,
   output logic sec_pulse
);
   localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

   if (TICK_DIV < 1) begin : g_bad_div
      $error("rtc_prescaler: TICK_DIV must be at least 1");
   end

   if (TICK_DIV == 1) begin : g_direct
      assign sec_pulse = tick_en & ~clear;
   end else begin : g_count
      logic [PW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n || clear)  cnt_q <= '0;
         else if (tick_en)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      assign sec_pulse = tick_en && !clear && (cnt_q == LAST);

      p_clear_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
         clear |=> !sec_pulse);
   end

   p_step_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |-> tick_en);

endmodule

// File: rtl/rtc_counter_chain.sv
module rtc_counter_chain
   import rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sec_pulse,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t cnt
);
   rtc_time_t cnt_q, nxt;
   logic [8:0] s_sec, s_min, s_hour, s_day, s_date, s_mon, s_year;

   always_comb begin
      s_sec  = bcd_step(cnt_q.second, 8'h59, 8'h00);
      s_min  = bcd_step(cnt_q.minute, 8'h59, 8'h00);
      s_hour = bcd_step(cnt_q.hour,   8'h23, 8'h00);
      s_day  = bcd_step(cnt_q.day,    8'h07, 8'h01);
      s_date = bcd_step(cnt_q.date, last_date(cnt_q.month, cnt_q.year), 8'h01);
      s_mon  = bcd_step(cnt_q.month,  8'h12, 8'h01);
      s_year = bcd_step(cnt_q.year,   8'h99, 8'h00);

      nxt = cnt_q;
      nxt.second = s_sec[7:0];
      if (s_sec[8]) begin
         nxt.minute = s_min[7:0];
         if (s_min[8]) begin
            nxt.hour = s_hour[7:0];
            if (s_hour[8]) begin
               nxt.day  = s_day[7:0];
               nxt.date = s_date[7:0];
               if (s_date[8]) begin
                  nxt.month = s_mon[7:0];
                  if (s_mon[8]) nxt.year = s_year[7:0];
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= RTC_INIT;
      else if (load)       cnt_q <= load_val;
      else if (sec_pulse)  cnt_q <= nxt;
   end

   assign cnt = cnt_q;

   p_load_all_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(load_val));

   p_minute_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse && !load && cnt.second == 8'h59 && cnt.minute == 8'h12
      |=> cnt.second == 8'h00 && cnt.minute == 8'h13);

   p_leap_feb_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse && !load && cnt.month == 8'h02 && cnt.date == 8'h29 &&
      cnt.hour == 8'h23 && cnt.minute == 8'h59 && cnt.second == 8'h59
      |=> cnt.month == 8'h03 && cnt.date == 8'h01);

   p_year_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse && !load && cnt.month == 8'h12 && cnt.date == 8'h31 &&
      cnt.hour == 8'h23 && cnt.minute == 8'h59 && cnt.second == 8'h59 &&
      cnt.year == 8'h99
      |=> cnt.year == 8'h00 && cnt.month == 8'h01);

endmodule

// File: rtl/rtc_window.sv
module rtc_window
   import rtc_pkg::*;
#(
   parameter int HOLD_BIT = 6,
   parameter int SET_BIT  = 7,
   parameter bit RD_REG   = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_we,
   input  logic [2:0] host_addr,
   input  logic [7:0] host_wdata,
   input  logic       sec_pulse,
   input  rtc_time_t  cnt,
   output logic [7:0] host_rdata,
   output logic       load,
   output rtc_time_t  vis
);
   if (HOLD_BIT == SET_BIT || HOLD_BIT > 7 || SET_BIT > 7 ||
       HOLD_BIT < 0 || SET_BIT < 0) begin : g_bad_bits
      $error("rtc_window: freeze bit positions must be distinct and within a byte");
   end

   rtc_time_t  vis_q;
   logic       hold_q, set_q, pend_q;
   logic       ctrl_wr, fld_wr, copy_now;
   logic [7:0] ctrl_byte, rd_mux;

   assign ctrl_wr  = host_we && (host_addr == OFS_CTRL);
   assign fld_wr   = host_we && (host_addr != OFS_CTRL) && set_q;
   assign load     = ctrl_wr && set_q && !host_wdata[SET_BIT];
   assign copy_now = pend_q && !hold_q && !set_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         set_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= sec_pulse && !load;
         if (ctrl_wr) begin
            hold_q <= host_wdata[HOLD_BIT];
            set_q  <= host_wdata[SET_BIT];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          vis_q <= RTC_INIT;
      else if (copy_now)   vis_q <= cnt;
      else if (fld_wr) begin
         case (host_addr)
            OFS_SEC:   vis_q.second <= host_wdata;
            OFS_MIN:   vis_q.minute <= host_wdata;
            OFS_HOUR:  vis_q.hour   <= host_wdata;
            OFS_DAY:   vis_q.day    <= host_wdata;
            OFS_DATE:  vis_q.date   <= host_wdata;
            OFS_MONTH: vis_q.month  <= host_wdata;
            OFS_YEAR:  vis_q.year   <= host_wdata;
            default:   ;
         endcase
      end
   end

   always_comb begin
      ctrl_byte = '0;
      ctrl_byte[HOLD_BIT] = hold_q;
      ctrl_byte[SET_BIT]  = set_q;
      case (host_addr)
         OFS_CTRL:  rd_mux = ctrl_byte;
         OFS_SEC:   rd_mux = vis_q.second;
         OFS_MIN:   rd_mux = vis_q.minute;
         OFS_HOUR:  rd_mux = vis_q.hour;
         OFS_DAY:   rd_mux = vis_q.day;
         OFS_DATE:  rd_mux = vis_q.date;
         OFS_MONTH: rd_mux = vis_q.month;
         default:   rd_mux = vis_q.year;
      endcase
   end

   if (RD_REG) begin : g_rd_flop
      logic [7:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_mux;
      end
      assign host_rdata = rd_q;
   end else begin : g_rd_comb
      assign host_rdata = rd_mux;
   end

   assign vis = vis_q;

   p_copy_whole_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !hold_q && !set_q |=> vis == $past(cnt));

   p_hold_keeps_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q && !set_q |=> $stable(vis));

   p_freeze_not_cutting_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !hold_q && !set_q && ctrl_wr && host_wdata[HOLD_BIT]
      |=> hold_q && vis == $past(cnt));

   p_unarmed_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !set_q && !pend_q |=> $stable(vis));

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
   import rtc_pkg::*;
#(
   parameter int TICK_DIV = 32768,
   parameter int HOLD_BIT = 6,
   parameter int SET_BIT  = 7,
   parameter bit RD_REG   = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       host_we,
   input  logic [2:0] host_addr,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata
);
   logic      sec_pulse, load;
   rtc_time_t cnt, vis;

   rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .clear     (load),
      .sec_pulse (sec_pulse)
   );

   rtc_counter_chain u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_pulse (sec_pulse),
      .load      (load),
      .load_val  (vis),
      .cnt       (cnt)
   );

   rtc_window #(.HOLD_BIT(HOLD_BIT), .SET_BIT(SET_BIT), .RD_REG(RD_REG)) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .sec_pulse  (sec_pulse),
      .cnt        (cnt),
      .host_rdata (host_rdata),
      .load       (load),
      .vis        (vis)
   );

endmodule

// File: tb/sim_rtc_bcd_core.sv
module sim_rtc_bcd_core;
   localparam int CLK_PERIOD = 10;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       host_we = 1'b0;
   logic [2:0] host_addr = 3'd0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // expected time, binary: [1]sec [2]min [3]hour [4]day [5]date [6]month [7]year
   int e [1:7];

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_bcd_core #(.TICK_DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   function automatic logic [7:0] to_bcd(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic int mlen(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic model_step();
      e[1]++;
      if (e[1] == 60) begin
         e[1] = 0; e[2]++;
         if (e[2] == 60) begin
            e[2] = 0; e[3]++;
            if (e[3] == 24) begin
               e[3] = 0;
               e[4] = e[4] % 7 + 1;
               e[5]++;
               if (e[5] > mlen(e[6], e[7])) begin
                  e[5] = 1; e[6]++;
                  if (e[6] == 13) begin e[6] = 1; e[7] = (e[7] + 1) % 100; end
               end
            end
         end
      end
   endtask

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_en = 1'b1;
         @(negedge clk); tick_en = 1'b0;
      end
   endtask

   task automatic seconds(input int n);
      ticks(n * DIV);
      for (int i = 0; i < n; i++) model_step();
   endtask

   task automatic check_bank(input string req, input int snap [1:7]);
      logic [7:0] d;
      for (int k = 1; k <= 7; k++) begin
         rd(3'(k), d);
         check(req, $sformatf("offset %0d", k), d, to_bcd(snap[k]));
      end
   endtask

   task automatic set_time(input int s, input int mi, input int h, input int dw,
                           input int dt, input int mo, input int y);
      wr(3'd0, 8'h80);
      e[1] = s; e[2] = mi; e[3] = h; e[4] = dw; e[5] = dt; e[6] = mo; e[7] = y;
      for (int k = 1; k <= 7; k++) wr(3'(k), to_bcd(e[k]));
      wr(3'd0, 8'h00);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int snap [1:7];
      e[1] = 0; e[2] = 0; e[3] = 0; e[4] = 1; e[5] = 1; e[6] = 1; e[7] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset contents
      check_bank("R1", e);
      rd(3'd0, d); check("R1", "control", d, 8'h00);

      // R2/R3: DIV-1 enables give nothing, the DIV-th steps one second
      ticks(DIV - 1);
      rd(3'd1, d); check("R2", "sec before last tick", d, 8'h00);
      ticks(1); model_step();
      check_bank("R3", e);

      // R7: write with set bit clear is ignored
      wr(3'd1, 8'h33);
      rd(3'd1, d); check("R7", "unarmed write", d, 8'h01);

      // R8/R9/R11: load end of century, step into new year
      set_time(50, 59, 23, 7, 31, 12, 99);
      check_bank("R8", e);
      seconds(10);
      check_bank("R11", e);
      rd(3'd4, d); check("R9", "day wrap", d, 8'h01);

      // R4/R6: hold freezes, counters keep running
      wr(3'd0, 8'h40);
      rd(3'd0, d); check("R4", "control hold", d, 8'h40);
      snap = e;
      seconds(5);
      check_bank("R4", snap);
      wr(3'd0, 8'h00);
      check_bank("R6", snap);
      seconds(1);
      check_bank("R6", e);

      // R5: hold written in the cycle after a step still sees the copy
      ticks(DIV - 1);
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      host_we = 1'b1; host_addr = 3'd0; host_wdata = 8'h40;
      @(negedge clk); host_we = 1'b0;
      model_step();
      snap = e;
      check_bank("R5", snap);
      seconds(2);
      check_bank("R5", snap);
      wr(3'd0, 8'h00);
      seconds(1);

      // R8: load clears the prescaler
      ticks(2);
      set_time(10, 0, 12, 3, 15, 6, 20);
      ticks(DIV - 1);
      rd(3'd1, d); check("R8", "no step before full count", d, 8'h10);
      ticks(1); model_step();
      rd(3'd1, d); check("R8", "step after full count", d, 8'h11);

      // R10/R11: every month end over four years
      for (int y = 0; y < 4; y++) begin
         for (int m = 1; m <= 12; m++) begin
            set_time(59, 59, 23, 2, mlen(m, y), m, y);
            seconds(1);
            rd(3'd5, d); check("R10", $sformatf("date y%0d m%0d", y, m), d, to_bcd(e[5]));
            rd(3'd6, d); check("R10", $sformatf("month y%0d m%0d", y, m), d, to_bcd(e[6]));
            rd(3'd7, d); check("R11", $sformatf("year y%0d m%0d", y, m), d, to_bcd(e[7]));
         end
      end

      // R12: out-of-range seconds stored, loaded, wrapped
      set_time(0, 4, 1, 1, 1, 1, 0);
      wr(3'd0, 8'h80);
      wr(3'd1, 8'h7A);
      rd(3'd1, d); check("R12", "stored raw", d, 8'h7A);
      wr(3'd0, 8'h00);
      rd(3'd1, d); check("R12", "kept after load", d, 8'h7A);
      ticks(DIV);
      rd(3'd1, d); check("R12", "sec wrapped", d, 8'h00);
      rd(3'd2, d); check("R12", "carry to min", d, 8'h05);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule